// File: doc/BRIEF.md
# Out-of-Order Receive Fill Tracker

This block keeps count of which parts of a circular receive region have been written when data segments arrive in any order. Each segment is reported by its starting byte address and byte length. The block holds a bitmap of 16-byte chunks for a window just beyond the committed write pointer. It publishes a write pointer that moves only across bytes filled without a gap. When a late segment closes a hole, the pointer jumps forward over every chunk that is now contiguous. It scans a bounded number of chunks each cycle.

The user consumes data and moves the read pointer. The block reports how many bytes may still be committed, which the user can hand to flow control. A segment can carry a finish mark, which records the final size of the stream. The finish flag rises once the write pointer reaches that final position. A clear command empties the region for a new connection by setting the write pointer equal to the read pointer.

Segments come in on a valid/ready interface. `seg_ready` is low only in a cycle where `clr` is high. A segment is taken on a rising clock edge where both `seg_valid` and `seg_ready` are high. The source holds its fields stable while `seg_ready` is low. The control and status pins carry no handshake.

Top module: `rx_fill_tracker`

## Requirements
- R1: After reset, `wr_ptr` is 0 and `fin_done` is 0. One cycle after `clr` is sampled high, `wr_ptr` equals the `rd_ptr` sampled with it, `fin_done` is 0 and all tracked chunks are empty.
- R2: `free_bytes` always equals (`rd_ptr` - `wr_ptr` - 1) modulo 2^18. A region is full at one byte short of 256 KB, so equal pointers always mean empty.
- R3: A segment that starts past the committed write pointer is held. It leaves `wr_ptr` unchanged until the gap before it is filled.
- R4: Once the chunk at `wr_ptr` is filled, `wr_ptr` moves over the contiguous filled run. The first step happens on the clock edge after the segment is taken. It advances by at most SCAN chunks (default 4, that is 64 bytes) per cycle, ending at the end of the run.
- R5: A segment is rejected if its end, measured from `wr_ptr`, exceeds `free_bytes`. A rejected segment has no effect and raises `flow_err` for one cycle, starting at the edge where it was taken. Stale duplicates that start behind `wr_ptr` fall under this rule.
- R6: Two cases break alignment. One is a start offset from `wr_ptr` that is not a multiple of 16. The other is a length that is not a multiple of 16 on a segment without the finish mark. Either case rejects the segment with a one-cycle `range_err` and no other effect.
- R7: A segment whose end lies more than 1024 bytes (the 64-chunk window) beyond `wr_ptr` is rejected with `range_err`.
- R8: A segment taken with `seg_fin` high records `seg_off + seg_len` as the final position. When the committed run reaches it, `wr_ptr` stops exactly there, even mid-chunk, and `fin_done` rises.
- R9: After a final position is recorded, a segment ending past it is rejected with `range_err`. After `fin_done` rises, segments are taken but ignored: no error is raised and `wr_ptr` stays fixed.
- R10: All pointers are 18-bit byte addresses that wrap modulo 2^18. A segment crossing the top of the region commits to a wrapped `wr_ptr`.
- R11: `seg_ready` is 0 while `clr` is 1 and 1 otherwise. `flow_err` and `range_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Empty the region for a new connection |
| rd_ptr | input | 18 | User read pointer (byte address) |
| seg_valid | input | 1 | Segment report is valid |
| seg_ready | output | 1 | Block can take a segment report |
| seg_off | input | 18 | Byte address of the first byte written |
| seg_len | input | 11 | Number of bytes written |
| seg_fin | input | 1 | Segment ends the stream |
| wr_ptr | output | 18 | Committed write pointer |
| fin_done | output | 1 | Committed pointer has reached the final position |
| free_bytes | output | 18 | Bytes that may still be committed |
| flow_err | output | 1 | One-cycle pulse: segment overran the read pointer |
| range_err | output | 1 | One-cycle pulse: segment misaligned, outside the window or past the final position |

## Verification
The assertions assume that `rd_ptr` moves only forward and never past `wr_ptr`. They also assume that a final position, once reported, is never below chunks already held, and that `clr` is the only way to start a new stream. The stimulus moves `rd_ptr` only between segments, and only to values at or ahead of the committed pointer for a new connection. It sends at most one finish mark per stream, and that mark lies beyond every held chunk. Within those limits, a step of `wr_ptr` beyond SCAN chunks, a pointer that moves after finish, or a paired error pulse shows a fault in the design itself.

// File: rtl/rft_pkg.sv
package rft_pkg;
  // outcome of the admission checks for one offered segment
  typedef enum logic [1:0] {
    ADM_TAKE  = 2'd0,
    ADM_DROP  = 2'd1,
    ADM_FLOW  = 2'd2,
    ADM_RANGE = 2'd3
  } verdict_t;
endpackage

// File: rtl/rft_admit.sv
module rft_admit
  import rft_pkg::*;
#(
  parameter int PTR_W    = 18,
  parameter int CHUNK_LG = 4,
  parameter int WIN_LG   = 6,
  parameter int LEN_W    = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seg_valid,
  input  logic                seg_ready,
  input  logic [PTR_W-1:0]    seg_off,
  input  logic [LEN_W-1:0]    seg_len,
  input  logic                seg_fin,
  input  logic [PTR_W-1:0]    wr_ptr,
  input  logic [PTR_W-1:0]    rd_ptr,
  input  logic [WIN_LG-1:0]   head,
  input  logic                fin_seen,
  input  logic [PTR_W-1:0]    fin_pos,
  input  logic                done,
  output logic                mark_en,
  output logic [WIN_LG-1:0]   mark_idx,
  output logic [WIN_LG:0]     mark_cnt,
  output logic                fin_set,
  output logic [PTR_W-1:0]    fin_pos_new,
  output logic                flow_err,
  output logic                range_err
);
  localparam int CHUNK     = 1 << CHUNK_LG;
  localparam int WIN_BYTES = 1 << (WIN_LG + CHUNK_LG);

  logic [PTR_W-1:0] d_start, room, fin_dist;
  logic [PTR_W:0]   d_end;
  logic [LEN_W:0]   cnt_full;
  logic             misalign, overrun, outwin, past_fin, take;
  verdict_t         verdict;

  assign take     = seg_valid && seg_ready;
  assign d_start  = seg_off - wr_ptr;
  assign d_end    = {1'b0, d_start} + (PTR_W+1)'(seg_len);
  assign room     = rd_ptr - wr_ptr - PTR_W'(1);
  assign fin_dist = fin_pos - wr_ptr;

  assign misalign = (|d_start[CHUNK_LG-1:0]) || (!seg_fin && (|seg_len[CHUNK_LG-1:0]));
  assign overrun  = d_end > {1'b0, room};
  assign outwin   = d_end > (PTR_W+1)'(WIN_BYTES);
  assign past_fin = fin_seen && (d_end > {1'b0, fin_dist});

  always_comb begin
    if (done)                               verdict = ADM_DROP;
    else if (overrun)                       verdict = ADM_FLOW;
    else if (misalign || outwin || past_fin) verdict = ADM_RANGE;
    else                                    verdict = ADM_TAKE;
  end

  assign cnt_full    = ({1'b0, seg_len} + (LEN_W+1)'(CHUNK - 1)) >> CHUNK_LG;
  assign mark_en     = take && (verdict == ADM_TAKE);
  assign mark_idx    = head + d_start[CHUNK_LG +: WIN_LG];
  assign mark_cnt    = (WIN_LG+1)'(cnt_full);
  assign fin_set     = mark_en && seg_fin;
  assign fin_pos_new = seg_off + PTR_W'(seg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_err  <= 1'b0;
      range_err <= 1'b0;
    end else begin
      flow_err  <= take && (verdict == ADM_FLOW);
      range_err <= take && (verdict == ADM_RANGE);
    end
  end
endmodule

// File: rtl/rft_bitmap.sv
module rft_bitmap #(
  parameter int WIN_LG = 6,
  parameter int SCAN   = 4,
  parameter int RUN_W  = $clog2(SCAN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mark_en,
  input  logic [WIN_LG-1:0] mark_idx,
  input  logic [WIN_LG:0]   mark_cnt,
  input  logic [WIN_LG-1:0] head,
  output logic [RUN_W-1:0]  run_len
);
  localparam int WIN = 1 << WIN_LG;

  logic [WIN-1:0]  map_q, set_v, drop_v;
  logic [SCAN-1:0] look;

  for (genvar i = 0; i < WIN; i++) begin : g_bit
    localparam int unsigned IDX = i;
    logic [WIN_LG-1:0] rel_set, rel_head;
    assign rel_set   = WIN_LG'(IDX) - mark_idx;
    assign rel_head  = WIN_LG'(IDX) - head;
    assign set_v[i]  = mark_en && ({1'b0, rel_set} < mark_cnt);
    assign drop_v[i] = {1'b0, rel_head} < (WIN_LG+1)'(run_len);
  end

  for (genvar j = 0; j < SCAN; j++) begin : g_look
    localparam int unsigned OFS = j;
    assign look[j] = map_q[head + WIN_LG'(OFS)];
  end

  always_comb begin
    logic run;
    run     = 1'b1;
    run_len = '0;
    for (int j = 0; j < SCAN; j++) begin
      if (run && look[j]) run_len = run_len + RUN_W'(1);
      else                run     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   map_q <= '0;
    else if (clr) map_q <= '0;
    else          map_q <= (map_q | set_v) & ~drop_v;
  end
endmodule

// File: rtl/rft_commit.sv
module rft_commit #(
  parameter int PTR_W    = 18,
  parameter int CHUNK_LG = 4,
  parameter int WIN_LG   = 6,
  parameter int RUN_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [RUN_W-1:0]  run_len,
  input  logic              fin_set,
  input  logic [PTR_W-1:0]  fin_pos_new,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [WIN_LG-1:0] head,
  output logic              fin_seen,
  output logic [PTR_W-1:0]  fin_pos,
  output logic              done
);
  logic [PTR_W-1:0] adv, fin_dist;

  assign adv      = PTR_W'(run_len) << CHUNK_LG;
  assign fin_dist = fin_pos - wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      head     <= '0;
      fin_seen <= 1'b0;
      fin_pos  <= '0;
      done     <= 1'b0;
    end else if (clr) begin
      wr_ptr   <= rd_ptr;
      head     <= '0;
      fin_seen <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (!done) begin
        if (fin_seen && (fin_dist <= adv)) begin
          wr_ptr <= fin_pos;
          done   <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + adv;
          head   <= head + WIN_LG'(run_len);
        end
      end
      if (fin_set) begin
        fin_seen <= 1'b1;
        fin_pos  <= fin_pos_new;
      end
    end
  end
endmodule

// File: rtl/rx_fill_tracker.sv
module rx_fill_tracker #(
  parameter int PTR_W    = 18,
  parameter int CHUNK_LG = 4,
  parameter int WIN_LG   = 6,
  parameter int SCAN     = 4,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [PTR_W-1:0] seg_off,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_fin,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             fin_done,
  output logic [PTR_W-1:0] free_bytes,
  output logic             flow_err,
  output logic             range_err
);
  localparam int RUN_W = $clog2(SCAN + 1);

  logic [WIN_LG-1:0] head, mark_idx;
  logic [WIN_LG:0]   mark_cnt;
  logic [RUN_W-1:0]  run_len;
  logic [PTR_W-1:0]  fin_pos, fin_pos_new;
  logic              fin_seen, mark_en, fin_set;

  assign seg_ready  = !clr;
  assign free_bytes = rd_ptr - wr_ptr - PTR_W'(1);

  rft_admit #(
    .PTR_W(PTR_W), .CHUNK_LG(CHUNK_LG), .WIN_LG(WIN_LG), .LEN_W(LEN_W)
  ) u_admit (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_off(seg_off), .seg_len(seg_len), .seg_fin(seg_fin),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .head(head),
    .fin_seen(fin_seen), .fin_pos(fin_pos), .done(fin_done),
    .mark_en(mark_en), .mark_idx(mark_idx), .mark_cnt(mark_cnt),
    .fin_set(fin_set), .fin_pos_new(fin_pos_new),
    .flow_err(flow_err), .range_err(range_err)
  );

  rft_bitmap #(
    .WIN_LG(WIN_LG), .SCAN(SCAN), .RUN_W(RUN_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .mark_en(mark_en), .mark_idx(mark_idx), .mark_cnt(mark_cnt),
    .head(head), .run_len(run_len)
  );

  rft_commit #(
    .PTR_W(PTR_W), .CHUNK_LG(CHUNK_LG), .WIN_LG(WIN_LG), .RUN_W(RUN_W)
  ) u_commit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_ptr(rd_ptr),
    .run_len(run_len), .fin_set(fin_set), .fin_pos_new(fin_pos_new),
    .wr_ptr(wr_ptr), .head(head), .fin_seen(fin_seen),
    .fin_pos(fin_pos), .done(fin_done)
  );
endmodule

// File: rtl/rx_fill_tracker_chk.sv
module rx_fill_tracker_chk #(
  parameter int PTR_W    = 18,
  parameter int CHUNK_LG = 4,
  parameter int SCAN     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             fin_done,
  input logic             flow_err,
  input logic             range_err
);
  localparam logic [PTR_W-1:0] STEP_MAX = PTR_W'(SCAN << CHUNK_LG);

  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_ptr == $past(rd_ptr)) && !fin_done);

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> PTR_W'(wr_ptr - $past(wr_ptr)) <= STEP_MAX);

  // R9
  frozen_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_done && !clr) |=> $stable(wr_ptr));

  // R11
  single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flow_err && range_err));

  // R5
  err_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_err || range_err) |-> $past(seg_valid && seg_ready));
endmodule

bind rx_fill_tracker rx_fill_tracker_chk #(
  .PTR_W(PTR_W), .CHUNK_LG(CHUNK_LG), .SCAN(SCAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rd_ptr(rd_ptr),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .wr_ptr(wr_ptr),
  .fin_done(fin_done), .flow_err(flow_err), .range_err(range_err)
);

// File: tb/test_rx_fill_tracker.sv
module test_rx_fill_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [17:0] rd_ptr = '0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [17:0] seg_off = '0;
  logic [10:0] seg_len = '0;
  logic        seg_fin = 1'b0;
  logic [17:0] wr_ptr;
  logic        fin_done;
  logic [17:0] free_bytes;
  logic        flow_err, range_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_fill_tracker i_rx_fill_tracker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_ptr(rd_ptr),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_off(seg_off), .seg_len(seg_len), .seg_fin(seg_fin),
    .wr_ptr(wr_ptr), .fin_done(fin_done), .free_bytes(free_bytes),
    .flow_err(flow_err), .range_err(range_err)
  );

  typedef struct packed {
    logic [17:0] rp;
    logic [17:0] off;
    logic [10:0] len;
    logic        fin;
    logic [17:0] ewp;
    logic        efl;
    logic        erg;
    logic        efin;
  } vec_t;

  // rd_ptr, offset, length, fin, expected wr_ptr, flow, range, fin_done
  localparam vec_t VECS [12] = '{
    '{18'd0,   18'd32,   11'd32,  1'b0, 18'd0,   1'b0, 1'b0, 1'b0}, // R3 gap held
    '{18'd0,   18'd96,   11'd16,  1'b0, 18'd0,   1'b0, 1'b0, 1'b0}, // R3
    '{18'd0,   18'd0,    11'd32,  1'b0, 18'd64,  1'b0, 1'b0, 1'b0}, // R4 hole filled
    '{18'd0,   18'd64,   11'd32,  1'b0, 18'd112, 1'b0, 1'b0, 1'b0}, // R4 jump past held chunk
    '{18'd0,   18'd120,  11'd16,  1'b0, 18'd112, 1'b0, 1'b1, 1'b0}, // R6 offset
    '{18'd0,   18'd112,  11'd20,  1'b0, 18'd112, 1'b0, 1'b1, 1'b0}, // R6 length
    '{18'd0,   18'd1136, 11'd16,  1'b0, 18'd112, 1'b0, 1'b1, 1'b0}, // R7 window
    '{18'd200, 18'd112,  11'd96,  1'b0, 18'd112, 1'b1, 1'b0, 1'b0}, // R5 overrun
    '{18'd200, 18'd112,  11'd80,  1'b0, 18'd192, 1'b0, 1'b0, 1'b0}, // R5 fits
    '{18'd200, 18'd192,  11'd8,   1'b1, 18'd192, 1'b1, 1'b0, 1'b0}, // R2 R5 full is one short
    '{18'd201, 18'd192,  11'd8,   1'b1, 18'd200, 1'b0, 1'b0, 1'b1}, // R8 fin mid-chunk
    '{18'd201, 18'd200,  11'd16,  1'b0, 18'd200, 1'b0, 1'b0, 1'b1}  // R9 ignored after fin
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // offer one segment; returns at the falling edge after it was taken
  task automatic send(input logic [17:0] off, input logic [10:0] len, input logic fin);
    @(negedge clk);
    seg_off = off; seg_len = len; seg_fin = fin; seg_valid = 1'b1;
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  task automatic do_clear(input logic [17:0] rp);
    @(negedge clk);
    rd_ptr = rp; clr = 1'b1;
    #0.5;
    chk("R11 ready low in clear", 32'(seg_ready), 32'd0);
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 empty free space, R11 ready
    chk("R1 reset wr_ptr", 32'(wr_ptr), 32'd0);
    chk("R1 reset fin_done", 32'(fin_done), 32'd0);
    chk("R2 reset free_bytes", 32'(free_bytes), 32'd262143);
    chk("R11 ready idle", 32'(seg_ready), 32'd1);
    chk("R11 no error after reset", 32'({flow_err, range_err}), 32'd0);

    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      rd_ptr = VECS[n].rp;
      send(VECS[n].off, VECS[n].len, VECS[n].fin);
      chk($sformatf("R5 flow_err vec%0d", n), 32'(flow_err), 32'(VECS[n].efl));
      chk($sformatf("R6 R7 range_err vec%0d", n), 32'(range_err), 32'(VECS[n].erg));
      settle();
      chk($sformatf("R3 R4 wr_ptr vec%0d", n), 32'(wr_ptr), 32'(VECS[n].ewp));
      chk($sformatf("R8 fin_done vec%0d", n), 32'(fin_done), 32'(VECS[n].efin));
      chk($sformatf("R2 free vec%0d", n), 32'(free_bytes),
          32'(18'(VECS[n].rp - VECS[n].ewp - 18'd1)));
    end

    // R1 clear to an unaligned read pointer
    do_clear(18'd5000);
    chk("R1 clear wr_ptr", 32'(wr_ptr), 32'd5000);
    chk("R1 clear fin_done", 32'(fin_done), 32'd0);
    chk("R2 clear free", 32'(free_bytes), 32'd262143);
    send(18'd5016, 11'd16, 1'b0);
    settle();
    chk("R3 held after clear", 32'(wr_ptr), 32'd5000);
    send(18'd5000, 11'd16, 1'b0);
    settle();
    chk("R4 commit after clear", 32'(wr_ptr), 32'd5032);
    chk("R2 free after commit", 32'(free_bytes), 32'd262111);

    // R10 wrap across the top of the region
    do_clear(18'd262100);
    send(18'd262100, 11'd64, 1'b0);
    settle();
    chk("R10 wrapped wr_ptr", 32'(wr_ptr), 32'd20);

    // R4 scan rate: 60 contiguous chunks
    send(18'd84, 11'd896, 1'b0);
    settle();
    chk("R3 large held block", 32'(wr_ptr), 32'd20);
    send(18'd20, 11'd64, 1'b0);
    @(negedge clk);
    chk("R4 first step four chunks", 32'(wr_ptr), 32'd84);
    settle();
    chk("R4 full run committed", 32'(wr_ptr), 32'd980);

    // R8 R9 finish received before its gap
    send(18'd1012, 11'd5, 1'b1);
    chk("R8 early fin accepted", 32'({flow_err, range_err}), 32'd0);
    settle();
    chk("R8 fin waits for gap", 32'(wr_ptr), 32'd980);
    chk("R8 fin_done low", 32'(fin_done), 32'd0);
    send(18'd1028, 11'd16, 1'b0);
    chk("R9 past final rejected", 32'(range_err), 32'd1);
    send(18'd980, 11'd32, 1'b0);
    settle();
    chk("R8 lands on final", 32'(wr_ptr), 32'd1017);
    chk("R8 fin_done high", 32'(fin_done), 32'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule